// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block feeds a MAC transmitter from a ring of two-word descriptors held in system memory. Each descriptor has an address word at byte offset 0, pointing to a buffer, and a control word at byte offset 4. The control word carries the buffer length, a frame-end marker, a CRC-suppress request, a ring-wrap marker and an ownership flag. After a start strobe the block walks the ring. For each descriptor it reads the control word and then the address word, fetches the buffer word by word, and sends its bytes out as a byte stream. When a buffer has been sent, the block writes the control word back with the ownership flag set.

The block stops when it meets a descriptor whose ownership flag is already set. At a frame boundary this is a normal stop. Inside a frame it is an error: the ring ran dry. An underrun also ends a frame. It occurs when the sink keeps asking for bytes while a buffer word is slow to arrive. In both error cases the block sends a closing abort beat and marks the frame's first descriptor with an error bit. A halt request lets the frame in progress finish before the busy status drops. Clearing the transmit enable returns the engine to idle and points it back at the ring base.

All three data paths use valid/ready handshakes. A memory read request is held until accepted, and only one read is outstanding at a time. The response comes back as a single `rsp_valid` cycle and cannot be stalled. On the byte stream and on the write-back port, a beat offered with ready low is held unchanged until it is taken.

Top module: `tdr_txq_reader`

## Requirements
- R1: For descriptor i the block reads the control word at ring_base+8*i+4 and then the address word at ring_base+8*i. It streams control bits [10:0] bytes from the buffer in rising address order. Bytes are taken from 32-bit little-endian words read at word-aligned addresses.
- R2: After a descriptor whose control bit 30 is set, the next descriptor fetched is index 0 at ring_base.
- R3: tx_sof is high only on the first byte of a frame. tx_eof is high only on the last byte of a buffer whose control bit 15 is set. The buffers before that one are joined into the same frame.
- R4: tx_nocrc on every beat of a frame equals control bit 16 of the frame's first descriptor.
- R5: Once a buffer's bytes have all been accepted, the block writes that descriptor's control word to ring_base+8*i+4, with bit 31 set and every other bit unchanged. A buffer of length zero sends no bytes and is still written back.
- R6: A control word with bit 31 set, fetched at a frame boundary, ends the run. Nothing is written back, tx_go drops, and the index stays on that descriptor, so the next start resumes there.
- R7: A control word with bit 31 set, fetched inside a frame, causes one abort beat (tx_abort=1, tx_eof=1, data 0). The block then writes the first descriptor's control word with bits 31 and 27 set, drops tx_go, and returns the index to ring_base.
- R8: If tx_ready is high for UR_LIMIT consecutive cycles while a buffer word is awaited, the block emits an abort beat. It then writes the first descriptor's control word with bits 31 and 28 set, drops tx_go, and returns the index to ring_base. Waiting with tx_ready low is not an underrun.
- R9: A halt_req pulse while busy lets the current frame finish and be written back. tx_go then drops without sending the next frame. A later start continues from the next descriptor.
- R10: While tx_en is low the engine is idle, the index returns to ring_base, and start has no effect.
- R11: tx_data and its flags hold steady while tx_valid is high and tx_ready is low. wb_addr and wb_data hold steady while wb_valid is high and wb_ready is low.
- R12: tx_go is low after reset and goes high in the cycle after an accepted start. While tx_go is low, no read, beat or write-back is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low resets the engine and the ring index |
| start | input | 1 | Start strobe |
| halt_req | input | 1 | Halt after the current frame |
| ring_base | input | AW | Byte address of descriptor 0 |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | AW | Word-aligned read byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Byte beat valid |
| tx_ready | input | 1 | Sink ready |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last beat of frame |
| tx_nocrc | output | 1 | Sink must not append CRC |
| tx_abort | output | 1 | Frame aborted; this beat carries no data |
| wb_valid | output | 1 | Descriptor write-back valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | AW | Write-back byte address |
| wb_data | output | 32 | Control word written back |
| tx_go | output | 1 | Engine busy |

## Verification
Some properties are checked on every cycle. These cover the hold rules on the byte stream and write-back port, the ownership bit in every write-back, the end marker on every abort beat, the quiet ports whenever the engine is idle, and the drop of busy after tx_en falls. The scenarios cover what needs a memory picture to judge. That means the byte order and lane selection for unaligned buffers, and the sof/eof placement across a multi-buffer frame. It also means the wrap back to the base, resuming on a released descriptor, the error bits and the index return after a dry ring or an underrun, the absence of an underrun while the sink stalls, and a halt that waits for the frame to end.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 11;
  localparam int BIT_LAST   = 15;
  localparam int BIT_NOCRC  = 16;
  localparam int BIT_EXH    = 27;
  localparam int BIT_UR     = 28;
  localparam int BIT_WRAP   = 30;
  localparam int BIT_OWNED  = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_CREQ, S_CWAIT, S_AREQ, S_AWAIT,
    S_DREQ, S_DWAIT, S_EMIT, S_WB, S_ABORT, S_EWB
  } tdr_state_e;
endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap,
  input  logic [AW-1:0] ring_base,
  output logic [AW-1:0] desc_addr
);
  localparam int PAD = AW - IDX_W - 3;

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= wrap ? '0 : idx + 1'b1;
  end

  assign desc_addr = ring_base + {{PAD{1'b0}}, idx, 3'b000};
endmodule

// File: rtl/tdr_underrun_timer.sv
module tdr_underrun_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic sink_ready,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !waiting) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (!sink_ready) begin
        cnt <= '0;
      end else if (cnt == CW'(LIMIT - 1)) begin
        expired <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdr_lane_pick.sv
module tdr_lane_pick #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]              word,
  input  logic [$clog2(DW/8)-1:0]    lane,
  output logic [7:0]                 byte_o
);
  localparam int LANES = DW / 8;

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane == i[$clog2(DW/8)-1:0]) byte_o = word[i*8 +: 8];
    end
  end
endmodule

// File: rtl/tdr_txq_reader.sv
module tdr_txq_reader
  import tdr_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IDX_W    = 8,
  parameter int UR_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              start,
  input  logic              halt_req,
  input  logic [AW-1:0]     ring_base,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AW-1:0]     rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_nocrc,
  output logic              tx_abort,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [AW-1:0]     wb_addr,
  output logic [WORD_W-1:0] wb_data,
  output logic              tx_go
);
  localparam int LANE_W = $clog2(WORD_W / 8);
  localparam logic [WORD_W-1:0] OWN_M = WORD_W'(1) << BIT_OWNED;
  localparam logic [WORD_W-1:0] UR_M  = WORD_W'(1) << BIT_UR;
  localparam logic [WORD_W-1:0] EXH_M = WORD_W'(1) << BIT_EXH;

  tdr_state_e        state;
  logic [WORD_W-1:0] ctrl_q, first_ctrl, word_q;
  logic [AW-1:0]     first_addr, buf_ptr, desc_addr;
  logic [LEN_W-1:0]  remain;
  logic              in_frame, sof_pend, halt_pend, err_ur;
  logic              ur_exp, ptr_clr, ptr_adv, creq_live, last_byte;
  logic [7:0]        lane_byte;

  // ring index and descriptor address
  assign ptr_clr = !tx_en || (state == S_EWB && wb_ready);
  assign ptr_adv = tx_en && state == S_WB && wb_ready;

  tdr_ring_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(ptr_adv),
    .wrap(ctrl_q[BIT_WRAP]), .ring_base(ring_base), .desc_addr(desc_addr)
  );

  tdr_underrun_timer #(.LIMIT(UR_LIMIT)) u_ur (
    .clk(clk), .rst_n(rst_n),
    .waiting(state == S_DREQ || state == S_DWAIT),
    .sink_ready(tx_ready), .expired(ur_exp)
  );

  tdr_lane_pick #(.DW(WORD_W)) u_lane (
    .word(word_q), .lane(buf_ptr[LANE_W-1:0]), .byte_o(lane_byte)
  );

  // request and stream outputs
  assign creq_live = state == S_CREQ && !(halt_pend && !in_frame);
  assign last_byte = remain == LEN_W'(1);

  always_comb begin
    rd_valid = creq_live || state == S_AREQ || (state == S_DREQ && !ur_exp);
    case (state)
      S_AREQ:  rd_addr = desc_addr;
      S_DREQ:  rd_addr = {buf_ptr[AW-1:LANE_W], {LANE_W{1'b0}}};
      default: rd_addr = desc_addr + AW'(4);
    endcase
  end

  assign tx_valid = state == S_EMIT || state == S_ABORT;
  assign tx_data  = state == S_EMIT ? lane_byte : 8'h00;
  assign tx_sof   = tx_valid && sof_pend;
  assign tx_abort = state == S_ABORT;
  assign tx_eof   = tx_abort || (state == S_EMIT && last_byte && ctrl_q[BIT_LAST]);
  assign tx_nocrc = tx_valid && first_ctrl[BIT_NOCRC];

  assign wb_valid = state == S_WB || state == S_EWB;
  assign wb_addr  = (state == S_EWB ? first_addr : desc_addr) + AW'(4);
  assign wb_data  = state == S_EWB ? (first_ctrl | OWN_M | (err_ur ? UR_M : EXH_M))
                                   : (ctrl_q | OWN_M);
  assign tx_go    = state != S_IDLE;

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      state      <= S_IDLE;
      in_frame   <= 1'b0;
      sof_pend   <= 1'b0;
      halt_pend  <= 1'b0;
      err_ur     <= 1'b0;
      ctrl_q     <= '0;
      first_ctrl <= '0;
      first_addr <= '0;
      buf_ptr    <= '0;
      remain     <= '0;
      word_q     <= '0;
    end else begin
      if (halt_req && state != S_IDLE) halt_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          in_frame  <= 1'b0;
          halt_pend <= 1'b0;
          if (start) state <= S_CREQ;
        end
        S_CREQ: begin
          if (halt_pend && !in_frame) state <= S_IDLE;
          else if (rd_ready)          state <= S_CWAIT;
        end
        S_CWAIT: if (rsp_valid) begin
          if (rsp_data[BIT_OWNED]) begin
            err_ur <= 1'b0;
            state  <= in_frame ? S_ABORT : S_IDLE;
          end else begin
            ctrl_q <= rsp_data;
            if (!in_frame) begin
              first_ctrl <= rsp_data;
              first_addr <= desc_addr;
              sof_pend   <= 1'b1;
            end
            state <= S_AREQ;
          end
        end
        S_AREQ: if (rd_ready) state <= S_AWAIT;
        S_AWAIT: if (rsp_valid) begin
          buf_ptr <= AW'(rsp_data);
          remain  <= ctrl_q[LEN_W-1:0];
          state   <= ctrl_q[LEN_W-1:0] == '0 ? S_WB : S_DREQ;
        end
        S_DREQ: begin
          if (ur_exp) begin
            err_ur <= 1'b1;
            state  <= S_ABORT;
          end else if (rd_ready) begin
            state <= S_DWAIT;
          end
        end
        S_DWAIT: if (rsp_valid) begin
          if (ur_exp) begin
            err_ur <= 1'b1;
            state  <= S_ABORT;
          end else begin
            word_q <= rsp_data;
            state  <= S_EMIT;
          end
        end
        S_EMIT: if (tx_ready) begin
          sof_pend <= 1'b0;
          buf_ptr  <= buf_ptr + AW'(1);
          remain   <= remain - 1'b1;
          if (last_byte)                        state <= S_WB;
          else if (&buf_ptr[LANE_W-1:0])        state <= S_DREQ;
        end
        S_WB: if (wb_ready) begin
          in_frame <= !ctrl_q[BIT_LAST];
          state    <= S_CREQ;
        end
        S_ABORT: if (tx_ready) begin
          sof_pend <= 1'b0;
          state    <= S_EWB;
        end
        S_EWB: if (wb_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdr_txq_checker.sv
module tdr_txq_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          rd_valid,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_sof,
  input logic          tx_eof,
  input logic          tx_abort,
  input logic          wb_valid,
  input logic          wb_ready,
  input logic [AW-1:0] wb_addr,
  input logic [31:0]   wb_data,
  input logic          tx_go
);
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && tx_en |=> tx_valid && $stable(tx_data) &&
    $stable(tx_sof) && $stable(tx_eof) && $stable(tx_abort));

  a_r11_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready && tx_en |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  a_r5_wb_owned: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data[31]);

  a_r7_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_abort |-> tx_eof);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_go |-> !tx_valid && !rd_valid && !wb_valid);

  a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_go);

  a_r12_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, tx_valid, wb_valid}));
endmodule

bind tdr_txq_reader tdr_txq_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rd_valid(rd_valid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_abort(tx_abort),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
  .wb_data(wb_data), .tx_go(tx_go)
);

// File: tb/tdr_txq_reader_tb_top.sv
module tdr_txq_reader_tb_top;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] WRP = 32'h4000_0000;
  localparam logic [31:0] LST = 32'h0000_8000;
  localparam logic [31:0] NCR = 32'h0001_0000;

  typedef struct packed {
    logic [15:0] addr;
    logic [10:0] len;
    logic        nocrc;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h0400, 11'd1,  1'b0},
    '{16'h0401, 11'd3,  1'b1},
    '{16'h0403, 11'd5,  1'b0},
    '{16'h0410, 11'd8,  1'b1},
    '{16'h0422, 11'd13, 1'b0},
    '{16'h0500, 11'd0,  1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, start = 1'b0, halt_req = 1'b0;
  logic [31:0] ring_base = '0;
  logic rd_valid, rd_ready, rsp_valid, tx_valid, tx_ready, wb_valid, wb_ready, tx_go;
  logic [31:0] rd_addr, rsp_data, wb_addr, wb_data;
  logic [7:0] tx_data;
  logic tx_sof, tx_eof, tx_nocrc, tx_abort;

  always #5 clk = ~clk;

  tdr_txq_reader dut_i (.*);

  // memory model, logs
  logic [31:0] dmem [64];
  logic        pend = 1'b0;
  int          dly = 0, lat = 0;
  logic [31:0] paddr = '0;
  logic        poke_en = 1'b0, log_clr = 1'b0;
  logic [5:0]  poke_idx = '0;
  logic [31:0] poke_val = '0;
  logic [6:0]  bn = '0;
  logic [2:0]  wbn = '0;
  logic [7:0]  bd [64];
  logic        bsof [64], beof [64], bnc [64], babt [64];
  logic [31:0] wa [8], wd [8];
  int          cyc = 0, n_chk = 0, n_err = 0;
  logic        rdy_mode = 1'b0, rdy_fix = 1'b1, wbm = 1'b0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rd_ready  = !pend;
  assign rsp_valid = pend && dly == 0;
  assign rsp_data  = paddr < 32'h100 ? dmem[paddr[7:2]] :
    {pat(paddr + 3), pat(paddr + 2), pat(paddr + 1), pat(paddr)};

  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin
      pend <= 1'b1; dly <= lat; paddr <= rd_addr;
    end else if (pend) begin
      if (dly == 0) pend <= 1'b0; else dly <= dly - 1;
    end
    if (poke_en) dmem[poke_idx] <= poke_val;
    if (wb_valid && wb_ready) dmem[wb_addr[7:2]] <= wb_data;
    if (log_clr) begin
      bn <= '0; wbn <= '0;
    end else begin
      if (tx_valid && tx_ready) begin
        bd[bn[5:0]] <= tx_data; bsof[bn[5:0]] <= tx_sof; beof[bn[5:0]] <= tx_eof;
        bnc[bn[5:0]] <= tx_nocrc; babt[bn[5:0]] <= tx_abort; bn <= bn + 1'b1;
      end
      if (wb_valid && wb_ready) begin
        wa[wbn] <= wb_addr; wd[wbn] <= wb_data; wbn <= wbn + 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= rdy_mode ? (cyc % 3 != 0) : rdy_fix;
    wb_ready <= wbm ? cyc[0] : 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    poke_en = 1'b1; poke_idx = idx[5:0]; poke_val = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic set_desc(input int i, input logic [31:0] a, input logic [31:0] c);
    poke(int'(ring_base >> 2) + 2 * i, a);
    poke(int'(ring_base >> 2) + 2 * i + 1, c);
  endtask

  task automatic clr_logs();
    log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic rewind();
    tx_en = 1'b0; @(negedge clk); tx_en = 1'b1; @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 3000; i++) begin
      if (!tx_go) break;
      @(negedge clk);
    end
    chk(!tx_go, tag, tx_go, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input string tag);
    clr_logs(); pulse_start(); wait_idle(tag);
  endtask

  task automatic chk_bytes(input string tag, input logic [31:0] a, input int n, input int off);
    for (int k = 0; k < n; k++)
      chk(bd[off + k] == pat(a + k), tag, bd[off + k], pat(a + k));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] c;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!tx_go && !tx_valid && !rd_valid && !wb_valid, "R12 reset quiet",
        {tx_go, tx_valid, rd_valid, wb_valid}, 0);
    rst_n = 1'b1; tx_en = 1'b1; lat = 0;
    @(negedge clk);

    // vector table: single-buffer frames (R1 R3 R4 R5 R6 R10)
    foreach (VEC[v]) begin
      rewind();
      c = {21'd0, VEC[v].len} | LST | (VEC[v].nocrc ? NCR : 32'h0);
      set_desc(0, {16'h0, VEC[v].addr}, c);
      set_desc(1, 32'h0, OWN);
      clr_logs();
      pulse_start();
      chk(tx_go, "R12 busy after start", tx_go, 1);
      wait_idle("R6 stop on owned");
      chk(bn == 7'(VEC[v].len), "R1 byte count", bn, VEC[v].len);
      chk_bytes("R1 bytes", {16'h0, VEC[v].addr}, int'(VEC[v].len), 0);
      for (int k = 0; k < int'(VEC[v].len); k++) begin
        chk(bsof[k] == (k == 0) && beof[k] == (k == int'(VEC[v].len) - 1),
            "R3 markers", {bsof[k], beof[k]}, 0);
        chk(bnc[k] == VEC[v].nocrc, "R4 nocrc", bnc[k], VEC[v].nocrc);
      end
      chk(wbn == 3'd1, "R6 one write-back", wbn, 1);
      chk(wa[0] == 32'h4 && wd[0] == (c | OWN), "R5 write-back", wd[0], c | OWN);
    end

    // R6 resume at the held index (index 1)
    set_desc(1, 32'h0C00, 32'd2 | LST);
    set_desc(2, 32'h0, OWN);
    run("R6 resume idle");
    chk(bn == 7'd2, "R6 resume count", bn, 2);
    chk_bytes("R6 resume bytes", 32'h0C00, 2, 0);
    chk(wa[0] == 32'hC, "R6 resume addr", wa[0], 32'hC);

    // R10 disabled start ignored
    tx_en = 1'b0; clr_logs(); pulse_start(); @(negedge clk);
    chk(!tx_go && bn == 0, "R10 start ignored", tx_go, 0);
    tx_en = 1'b1; @(negedge clk);

    // R3 R4 R11 multi-buffer frame with back-pressure
    ring_base = 32'h40; rewind();
    set_desc(0, 32'h0A00, 32'd3 | NCR);
    set_desc(1, 32'h0A05, 32'd2 | LST);
    set_desc(2, 32'h0, OWN);
    rdy_mode = 1'b1; wbm = 1'b1;
    run("R11 idle");
    rdy_mode = 1'b0; wbm = 1'b0;
    chk(bn == 7'd5, "R3 frame count", bn, 5);
    chk_bytes("R11 bytes", 32'h0A00, 3, 0);
    chk_bytes("R11 bytes", 32'h0A05, 2, 3);
    for (int k = 0; k < 5; k++) begin
      chk(bsof[k] == (k == 0) && beof[k] == (k == 4), "R3 joined markers", {bsof[k], beof[k]}, 0);
      chk(bnc[k], "R4 first nocrc", bnc[k], 1);
    end
    chk(wbn == 3'd2 && wd[0] == (32'd3 | NCR | OWN) && wa[1] == 32'h4C,
        "R5 per buffer", wd[0], 32'd3 | NCR | OWN);

    // R2 wrap
    rewind();
    set_desc(0, 32'h0B00, 32'd1 | LST);
    set_desc(1, 32'h0B10, 32'd1 | LST | WRP);
    set_desc(2, 32'h0, OWN);
    run("R2 idle");
    chk(bn == 7'd2 && wbn == 3'd2, "R2 two frames", bn, 2);
    set_desc(0, 32'h0B20, 32'd2 | LST);
    run("R2 idle");
    chk(bn == 7'd2 && bd[0] == pat(32'h0B20), "R2 back at base", bd[0], pat(32'h0B20));
    chk(wa[0] == 32'h44, "R2 base write", wa[0], 32'h44);

    // R7 exhaustion mid-frame
    rewind();
    set_desc(0, 32'h0600, 32'd2);
    set_desc(1, 32'h0, OWN);
    run("R7 idle");
    chk(bn == 7'd3 && babt[2] && beof[2] && bd[2] == 8'h00, "R7 abort beat", {babt[2], beof[2]}, 3);
    chk_bytes("R7 bytes", 32'h0600, 2, 0);
    chk(wbn == 3'd2 && wa[1] == 32'h44 && wd[1] == (32'd2 | OWN | 32'h0800_0000),
        "R7 error status", wd[1], 32'd2 | OWN | 32'h0800_0000);
    set_desc(0, 32'h0700, 32'd1 | LST);
    run("R7 idle");
    chk(bn == 7'd1 && bd[0] == pat(32'h0700), "R7 index at base", bd[0], pat(32'h0700));

    // R8 underrun
    rewind(); lat = 20;
    set_desc(0, 32'h0800, 32'd4 | LST);
    set_desc(1, 32'h0, OWN);
    run("R8 idle");
    chk(bn == 7'd1 && babt[0] && bsof[0] && beof[0], "R8 abort beat", bn, 1);
    chk(wbn == 3'd1 && wa[0] == 32'h44 && wd[0] == (32'd4 | LST | OWN | 32'h1000_0000),
        "R8 error status", wd[0], 32'd4 | LST | OWN | 32'h1000_0000);
    // R8 stalled sink is not an underrun
    rewind();
    set_desc(0, 32'h0800, 32'd4 | LST);
    rdy_fix = 1'b0; clr_logs(); pulse_start();
    repeat (80) @(negedge clk);
    chk(bn == 0 && tx_go, "R8 stalled", bn, 0);
    rdy_fix = 1'b1; wait_idle("R8 idle");
    chk(bn == 7'd4 && !babt[3] && beof[3], "R8 no underrun", bn, 4);
    chk(wd[0] == (32'd4 | LST | OWN), "R8 clean status", wd[0], 32'd4 | LST | OWN);
    lat = 0;

    // R9 halt after frame
    rewind();
    set_desc(0, 32'h0900, 32'd3 | LST);
    set_desc(1, 32'h0910, 32'd3 | LST);
    set_desc(2, 32'h0, OWN);
    clr_logs(); pulse_start();
    repeat (3) @(negedge clk);
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
    wait_idle("R9 idle");
    chk(bn == 7'd3 && wbn == 3'd1, "R9 frame finished", bn, 3);
    chk_bytes("R9 bytes", 32'h0900, 3, 0);
    run("R9 idle");
    chk(bn == 7'd3 && bd[0] == pat(32'h0910) && wa[0] == 32'h4C, "R9 continue", wa[0], 32'h4C);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule